// File: doc/BRIEF.md
# Two-Colour Hardware Cursor Overlay

This block draws a 64x64 pointer image over the video stream just before the pixel leaves for the digital-to-analog stage. The CPU programs it through one byte-wide port that works as an index/data pair. A write with the select line low loads an 8-bit index. A write with the select line high stores the byte into the register that index names. Through this port the CPU sets the pointer position, a hotspot offset, an enable flag, a foreground and a background colour, and the shape memory. The shape memory is loaded through an address pointer that advances by one after every data byte.

Each shape pixel carries two bits: an AND bit and an XOR bit. On every pixel clock the block takes the beam coordinate and finds where the image origin lies, which is the programmed position minus the hotspot. If the beam falls inside the 64x64 window, the block decodes the two shape bits for that beam position. The result shows the background colour, shows the foreground colour, passes the video pixel through, or passes the video pixel inverted. The result is registered, so the output pixel follows its beam coordinate by one clock.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is asserted the output pixel is 0. After reset every register is cleared, so the overlay is off and pixels pass through unchanged.
- R2: A write with `cfg_sel`=0 only loads the index and changes no register. A write with `cfg_sel`=1 updates the register named by the current index. Data written to an index outside the map (for example 0x07, 0x30, 0xFF) changes nothing.
- R3: Bit 6 of the control byte at index 0x06 turns the overlay on. The other seven bits of that byte have no effect. When bit 6 is 0, every output pixel equals the input pixel.
- R4: Index 0x08 sets the low 8 bits of the 10-bit shape address and index 0x09 sets its top 2 bits (data bits 1:0). Each byte written to index 0x0A is stored at the current address, and the address then advances by one, wrapping from 1023 to 0.
- R5: Shape byte address = row*16 + column/4. Within that byte, pixel p = column mod 4 takes its AND bit from bit 7-2p and its XOR bit from bit 6-2p.
- R6: The (AND, XOR) pair decodes as follows: (0,0) gives the background colour, (0,1) the foreground colour, (1,0) the input pixel, and (1,1) the bitwise inverse of the input pixel.
- R7: Position X is made of index 0x00 (low byte) and 0x01 (high byte); position Y of index 0x02 (low) and 0x03 (high). Hotspot X is at index 0x04 and hotspot Y at 0x05. Origin = position - hotspot, computed as a signed value. A pixel is a hit only when beam-origin lies in 0..63 on both axes; any other value, including a negative one, is a miss.
- R8: The foreground colour is set by R/G/B at indexes 0x26/0x27/0x28, and the background colour by R/G/B at 0x23/0x24/0x25. Pixels are packed {R[23:16], G[15:8], B[7:0]}.
- R9: When `vid_active` is low, the output pixel equals the input pixel, whatever the other settings are.
- R10: The output pixel for a given beam coordinate and input pixel appears on `pix_out` after the next rising clock edge, and not before it.
- R11: With position Y at 1663, no visible line (0..1199) shows the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_sel | input | 1 | 0: write to the index, 1: write to the data register |
| cfg_byte | input | 8 | Configuration write byte |
| vid_active | input | 1 | Beam is in the active display area |
| beam_x | input | COORD_W | Beam column |
| beam_y | input | COORD_W | Beam line |
| pix_in | input | 24 | Underlying RGB pixel |
| pix_out | output | 24 | RGB pixel after the overlay, registered |

## Verification
On every cycle, assertions check three things: the shape address steps by exactly one per shape write and holds otherwise; an index-only write leaves the position and enable untouched; and the output equals the delayed input whenever video is inactive or the overlay is off, or equals the foreground colour when that code is decoded. Only the bench scenarios can show that the hit window is correct, including its edges at offsets -1, 0, 63 and 64 with negative origins caused by the hotspot. The same goes for the bit order inside shape bytes, the address wrap from 1023 to 0, the parking of the pointer far below the visible area, and unmapped indexes having no effect. The bench checks each of these against a reference model of the whole mux.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int PIX_W  = 24;
  localparam int EN_BIT = 6;

  localparam logic [7:0] IX_XLO  = 8'h00;
  localparam logic [7:0] IX_XHI  = 8'h01;
  localparam logic [7:0] IX_YLO  = 8'h02;
  localparam logic [7:0] IX_YHI  = 8'h03;
  localparam logic [7:0] IX_HOTX = 8'h04;
  localparam logic [7:0] IX_HOTY = 8'h05;
  localparam logic [7:0] IX_CTRL = 8'h06;
  localparam logic [7:0] IX_ALO  = 8'h08;
  localparam logic [7:0] IX_AHI  = 8'h09;
  localparam logic [7:0] IX_RAMD = 8'h0A;
  localparam logic [7:0] IX_BG_R = 8'h23;
  localparam logic [7:0] IX_BG_G = 8'h24;
  localparam logic [7:0] IX_BG_B = 8'h25;
  localparam logic [7:0] IX_FG_R = 8'h26;
  localparam logic [7:0] IX_FG_G = 8'h27;
  localparam logic [7:0] IX_FG_B = 8'h28;

  typedef enum logic [1:0] {
    PX_BG   = 2'b00,
    PX_FG   = 2'b01,
    PX_PASS = 2'b10,
    PX_INV  = 2'b11
  } px_code_e;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [7:0]       wr_data,
  output logic [15:0]      pos_x,
  output logic [15:0]      pos_y,
  output logic [7:0]       hot_x,
  output logic [7:0]       hot_y,
  output logic             enable,
  output logic [PIX_W-1:0] fg_rgb,
  output logic [PIX_W-1:0] bg_rgb,
  output logic             ram_we,
  output logic [AW-1:0]    ram_addr,
  output logic [7:0]       ram_wdata
);
  logic [7:0]       idx_q, idx_d;
  logic [15:0]      posx_q, posx_d, posy_q, posy_d;
  logic [7:0]       hotx_q, hotx_d, hoty_q, hoty_d;
  logic             en_q, en_d;
  logic [PIX_W-1:0] fg_q, fg_d, bg_q, bg_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic             dwr;

  // next-state decode of the index/data pair
  always_comb begin
    idx_d  = idx_q;
    posx_d = posx_q;
    posy_d = posy_q;
    hotx_d = hotx_q;
    hoty_d = hoty_q;
    en_d   = en_q;
    fg_d   = fg_q;
    bg_d   = bg_q;
    addr_d = addr_q;
    ram_we = 1'b0;
    dwr    = wr_en && wr_sel;
    if (wr_en && !wr_sel) idx_d = wr_data;
    if (dwr) begin
      case (idx_q)
        IX_XLO:  posx_d[7:0]    = wr_data;
        IX_XHI:  posx_d[15:8]   = wr_data;
        IX_YLO:  posy_d[7:0]    = wr_data;
        IX_YHI:  posy_d[15:8]   = wr_data;
        IX_HOTX: hotx_d         = wr_data;
        IX_HOTY: hoty_d         = wr_data;
        IX_CTRL: en_d           = wr_data[EN_BIT];
        IX_ALO:  addr_d[7:0]    = wr_data;
        IX_AHI:  addr_d[AW-1:8] = wr_data[AW-9:0];
        IX_RAMD: begin
          ram_we = 1'b1;
          addr_d = addr_q + 1'b1;
        end
        IX_BG_R: bg_d[23:16] = wr_data;
        IX_BG_G: bg_d[15:8]  = wr_data;
        IX_BG_B: bg_d[7:0]   = wr_data;
        IX_FG_R: fg_d[23:16] = wr_data;
        IX_FG_G: fg_d[15:8]  = wr_data;
        IX_FG_B: fg_d[7:0]   = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      posx_q <= '0;
      posy_q <= '0;
      hotx_q <= '0;
      hoty_q <= '0;
      en_q   <= 1'b0;
      fg_q   <= '0;
      bg_q   <= '0;
      addr_q <= '0;
    end else if (wr_en) begin
      idx_q  <= idx_d;
      posx_q <= posx_d;
      posy_q <= posy_d;
      hotx_q <= hotx_d;
      hoty_q <= hoty_d;
      en_q   <= en_d;
      fg_q   <= fg_d;
      bg_q   <= bg_d;
      addr_q <= addr_d;
    end
  end

  assign pos_x     = posx_q;
  assign pos_y     = posy_q;
  assign hot_x     = hotx_q;
  assign hot_y     = hoty_q;
  assign enable    = en_q;
  assign fg_rgb    = fg_q;
  assign bg_rgb    = bg_q;
  assign ram_addr  = addr_q;
  assign ram_wdata = wr_data;

  // R4: the shape pointer advances by exactly one per stored byte
  p_ram_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> addr_q == $past(addr_q) + 1'b1);

  // R4: without a data write the shape pointer does not move
  p_ram_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dwr |=> $stable(addr_q));

  // R2: a write of the index alone changes no register
  p_idx_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> ($stable(posx_q) && $stable(posy_q) && $stable(en_q)));
endmodule

// File: rtl/cursor_shape_ram.sv
module cursor_shape_ram #(
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cursor_hit.sv
module cursor_hit #(
  parameter int CW  = 12,
  parameter int DIM = 64,
  localparam int DB = $clog2(DIM),
  localparam int AW = 2 * DB - 2
) (
  input  logic [CW-1:0] beam_x,
  input  logic [CW-1:0] beam_y,
  input  logic [15:0]   pos_x,
  input  logic [15:0]   pos_y,
  input  logic [7:0]    hot_x,
  input  logic [7:0]    hot_y,
  output logic          hit,
  output logic [AW-1:0] rd_addr,
  output logic [1:0]    pix_sel
);
  localparam int SW = 18;
  localparam logic signed [SW-1:0] DIM_S = SW'(DIM);

  logic signed [SW-1:0] org_x, org_y, dx, dy;
  logic in_x, in_y;

  always_comb begin
    org_x = $signed({2'b00, pos_x}) - $signed({10'b0, hot_x});
    org_y = $signed({2'b00, pos_y}) - $signed({10'b0, hot_y});
    dx    = $signed({{(SW-CW){1'b0}}, beam_x}) - org_x;
    dy    = $signed({{(SW-CW){1'b0}}, beam_y}) - org_y;
    in_x  = !dx[SW-1] && (dx < DIM_S);
    in_y  = !dy[SW-1] && (dy < DIM_S);
    hit   = in_x && in_y;
    rd_addr = {dy[DB-1:0], dx[DB-1:2]};
    pix_sel = dx[1:0];
  end
endmodule

// File: rtl/cursor_mux.sv
module cursor_mux
  import cursor_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             enable,
  input  logic             hit,
  input  logic [7:0]       shape_byte,
  input  logic [1:0]       pix_sel,
  input  logic [PIX_W-1:0] pix_in,
  input  logic [PIX_W-1:0] fg_rgb,
  input  logic [PIX_W-1:0] bg_rgb,
  output logic [PIX_W-1:0] pix_out
);
  logic             and_b, xor_b, show;
  px_code_e         code;
  logic [PIX_W-1:0] pix_d, pix_q;

  always_comb begin
    and_b = shape_byte[{~pix_sel, 1'b1}];
    xor_b = shape_byte[{~pix_sel, 1'b0}];
    code  = px_code_e'({and_b, xor_b});
    show  = active && enable && hit;
    pix_d = pix_in;
    if (show) begin
      case (code)
        PX_BG:   pix_d = bg_rgb;
        PX_FG:   pix_d = fg_rgb;
        PX_PASS: pix_d = pix_in;
        PX_INV:  pix_d = ~pix_in;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_q <= '0;
    else        pix_q <= pix_d;
  end

  assign pix_out = pix_q;

  // R9: outside active video the pixel goes through untouched
  p_blank_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> pix_out == $past(pix_in));

  // R3: overlay switched off means pass-through
  p_off_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> pix_out == $past(pix_in));

  // R6: a foreground code on a hit drives the foreground colour
  p_fg_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (show && code == PX_FG) |=> pix_out == $past(fg_rgb));
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int CUR_DIM = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic               cfg_sel,
  input  logic [7:0]         cfg_byte,
  input  logic               vid_active,
  input  logic [COORD_W-1:0] beam_x,
  input  logic [COORD_W-1:0] beam_y,
  input  logic [PIX_W-1:0]   pix_in,
  output logic [PIX_W-1:0]   pix_out
);
  localparam int DB    = $clog2(CUR_DIM);
  localparam int AW    = 2 * DB - 2;
  localparam int DEPTH = CUR_DIM * CUR_DIM / 4;

  logic [1:0]       rst_sync_q;
  logic             rst_s;
  logic [15:0]      pos_x, pos_y;
  logic [7:0]       hot_x, hot_y;
  logic             enable, hit, ram_we;
  logic [PIX_W-1:0] fg_rgb, bg_rgb;
  logic [AW-1:0]    ram_waddr, rd_addr;
  logic [7:0]       ram_wdata, shape_byte;
  logic [1:0]       pix_sel;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  cursor_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(cfg_wr), .wr_sel(cfg_sel), .wr_data(cfg_byte),
    .pos_x(pos_x), .pos_y(pos_y), .hot_x(hot_x), .hot_y(hot_y), .enable(enable),
    .fg_rgb(fg_rgb), .bg_rgb(bg_rgb), .ram_we(ram_we), .ram_addr(ram_waddr),
    .ram_wdata(ram_wdata)
  );

  cursor_shape_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(rd_addr), .rdata(shape_byte)
  );

  cursor_hit #(.CW(COORD_W), .DIM(CUR_DIM)) u_hit (
    .beam_x(beam_x), .beam_y(beam_y), .pos_x(pos_x), .pos_y(pos_y),
    .hot_x(hot_x), .hot_y(hot_y), .hit(hit), .rd_addr(rd_addr), .pix_sel(pix_sel)
  );

  cursor_mux u_mux (
    .clk(clk), .rst_n(rst_s), .active(vid_active), .enable(enable), .hit(hit),
    .shape_byte(shape_byte), .pix_sel(pix_sel), .pix_in(pix_in),
    .fg_rgb(fg_rgb), .bg_rgb(bg_rgb), .pix_out(pix_out)
  );
endmodule

// File: tb/tb_cursor_overlay.sv
module tb_cursor_overlay;
  logic        clk = 1'b0;
  logic        rst_n, cfg_wr, cfg_sel, vid_active;
  logic [7:0]  cfg_byte;
  logic [11:0] beam_x, beam_y;
  logic [23:0] pix_in, pix_out;

  always #4 clk = ~clk;

  cursor_overlay dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_byte(cfg_byte),
    .vid_active(vid_active), .beam_x(beam_x), .beam_y(beam_y), .pix_in(pix_in),
    .pix_out(pix_out)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference model state
  int          m_idx, m_posx, m_posy, m_hotx, m_hoty, m_addr;
  bit          m_en;
  logic [23:0] m_fg, m_bg;
  logic [7:0]  shape [1024];

  function automatic logic [23:0] ref_pix(int bx, int by, logic [23:0] pin, logic act);
    int dx, dy, p;
    logic [7:0] b;
    logic a, x;
    if (!act || !m_en) return pin;
    dx = bx - (m_posx - m_hotx);
    dy = by - (m_posy - m_hoty);
    if (dx < 0 || dx > 63 || dy < 0 || dy > 63) return pin;
    b = shape[dy * 16 + dx / 4];
    p = dx % 4;
    a = b[7 - 2 * p];
    x = b[6 - 2 * p];
    case ({a, x})
      2'b00:   return m_bg;
      2'b01:   return m_fg;
      2'b10:   return pin;
      default: return ~pin;
    endcase
  endfunction

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s got=%06h exp=%06h", tag, act, exp);
    end
  endtask

  task automatic put(input bit sel, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_byte = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (!sel) m_idx = int'(d);
    else begin
      case (m_idx)
        'h00: m_posx = (m_posx & 'hFF00) | int'(d);
        'h01: m_posx = (m_posx & 'h00FF) | (int'(d) << 8);
        'h02: m_posy = (m_posy & 'hFF00) | int'(d);
        'h03: m_posy = (m_posy & 'h00FF) | (int'(d) << 8);
        'h04: m_hotx = int'(d);
        'h05: m_hoty = int'(d);
        'h06: m_en   = d[6];
        'h08: m_addr = (m_addr & 'h300) | int'(d);
        'h09: m_addr = (m_addr & 'h0FF) | ((int'(d) & 3) << 8);
        'h0A: begin shape[m_addr] = d; m_addr = (m_addr + 1) & 1023; end
        'h23: m_bg[23:16] = d;
        'h24: m_bg[15:8]  = d;
        'h25: m_bg[7:0]   = d;
        'h26: m_fg[23:16] = d;
        'h27: m_fg[15:8]  = d;
        'h28: m_fg[7:0]   = d;
        default: ;
      endcase
    end
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] val);
    put(1'b0, idx);
    put(1'b1, val);
  endtask

  task automatic place(input int px, input int py, input int hx, input int hy);
    wr_reg(8'h00, 8'(px)); wr_reg(8'h01, 8'(px >> 8));
    wr_reg(8'h02, 8'(py)); wr_reg(8'h03, 8'(py >> 8));
    wr_reg(8'h04, 8'(hx)); wr_reg(8'h05, 8'(hy));
  endtask

  task automatic chk_pix(input string tag, input int bx, input int by,
                         input logic [23:0] pin, input logic act);
    logic [23:0] e;
    @(negedge clk);
    beam_x = 12'(bx); beam_y = 12'(by); pix_in = pin; vid_active = act;
    e = ref_pix(bx, by, pin, act);
    @(negedge clk);
    check(tag, pix_out, e);
  endtask

  task automatic rand_near(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      int bx, by;
      bx = (m_posx - m_hotx) + int'($urandom_range(0, 79)) - 8;
      by = (m_posy - m_hoty) + int'($urandom_range(0, 79)) - 8;
      if (bx < 0) bx = 0;
      if (by < 0) by = 0;
      chk_pix(tag, bx, by, 24'($urandom), 1'b1);
    end
  endtask

  initial begin
    logic [23:0] prev;
    void'($urandom(32'd2024));
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_byte = '0;
    vid_active = 1'b0; beam_x = '0; beam_y = '0; pix_in = '0;
    m_idx = 0; m_posx = 0; m_posy = 0; m_hotx = 0; m_hoty = 0; m_addr = 0;
    m_en = 0; m_fg = '0; m_bg = '0;
    for (int i = 0; i < 1024; i++) shape[i] = '0;
    repeat (4) @(negedge clk);
    check("R1 output held at zero in reset", pix_out, 24'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_pix("R1 overlay off after reset", 10, 10, 24'h123456, 1'b1);

    // colours and a full random shape streamed through the data index
    wr_reg(8'h26, 8'hFF); wr_reg(8'h27, 8'hEE); wr_reg(8'h28, 8'hDD);
    wr_reg(8'h23, 8'h11); wr_reg(8'h24, 8'h22); wr_reg(8'h25, 8'h33);
    wr_reg(8'h08, 8'h00); wr_reg(8'h09, 8'h00);
    put(1'b0, 8'h0A);
    for (int i = 0; i < 1024; i++) put(1'b1, 8'($urandom));
    place(100, 50, 0, 0);
    wr_reg(8'h06, 8'h40);
    rand_near("R4 R5 R6 R8 random shape window", 200);

    // window edges, origin (100,50)
    chk_pix("R7 edge dx=0 dy=0", 100, 50, 24'h0F0F0F, 1'b1);
    chk_pix("R7 edge dx=63", 163, 50, 24'h0F0F0F, 1'b1);
    chk_pix("R7 edge dx=64 miss", 164, 50, 24'h0F0F0F, 1'b1);
    chk_pix("R7 edge dx=-1 miss", 99, 50, 24'h0F0F0F, 1'b1);
    chk_pix("R7 edge dy=63", 100, 113, 24'h0F0F0F, 1'b1);
    chk_pix("R7 edge dy=64 miss", 100, 114, 24'h0F0F0F, 1'b1);
    chk_pix("R7 edge dy=-1 miss", 100, 49, 24'h0F0F0F, 1'b1);
    chk_pix("R7 corner 63,63", 163, 113, 24'h0F0F0F, 1'b1);

    // hotspot larger than position: origin (-15,-20)
    place(5, 10, 20, 30);
    rand_near("R7 hotspot negative origin", 150);
    chk_pix("R7 hotspot beam 0,0", 0, 0, 24'hA5A5A5, 1'b1);
    chk_pix("R7 hotspot last column", 48, 43, 24'hA5A5A5, 1'b1);
    chk_pix("R7 hotspot past column", 49, 43, 24'hA5A5A5, 1'b1);
    chk_pix("R7 hotspot past line", 48, 44, 24'hA5A5A5, 1'b1);

    // control byte
    wr_reg(8'h06, 8'hBF);
    rand_near("R3 enable bit 6 clear", 30);
    wr_reg(8'h06, 8'hC0);
    rand_near("R3 other control bits ignored", 30);

    // blanking
    for (int i = 0; i < 20; i++)
      chk_pix("R9 inactive video passes", int'($urandom_range(0, 60)),
              int'($urandom_range(0, 40)), 24'($urandom), 1'b0);

    // unmapped indexes and index-only writes
    wr_reg(8'h07, 8'($urandom));
    wr_reg(8'h30, 8'($urandom));
    wr_reg(8'hFF, 8'($urandom));
    put(1'b0, 8'h00);
    put(1'b0, 8'h06);
    rand_near("R2 unmapped and index-only writes ignored", 40);

    // address wrap and directed decode
    place(200, 200, 0, 0);
    wr_reg(8'h08, 8'hFF); wr_reg(8'h09, 8'h03);
    put(1'b0, 8'h0A);
    put(1'b1, 8'hE4);
    put(1'b1, 8'h1B);
    for (int c = 0; c < 4; c++)
      chk_pix("R4 R5 byte at address 1023", 260 + c, 263, 24'($urandom), 1'b1);
    for (int c = 0; c < 4; c++)
      chk_pix("R4 R6 R8 wrapped byte at address 0", 200 + c, 200, 24'h3C5A69, 1'b1);
    chk_pix("R6 R8 directed background", 200, 200, 24'h777777, 1'b1);
    check("R6 R8 background literal", pix_out, 24'h112233);
    chk_pix("R6 R8 directed foreground", 201, 200, 24'h777777, 1'b1);
    check("R6 R8 foreground literal", pix_out, 24'hFFEEDD);
    chk_pix("R6 directed invert", 203, 200, 24'h00FF0F, 1'b1);
    check("R6 invert literal", pix_out, 24'hFF00F0);

    // registered output timing
    @(negedge clk);
    prev = pix_out;
    beam_x = 12'd201; beam_y = 12'd200; pix_in = 24'h010203; vid_active = 1'b1;
    #1;
    check("R10 output unchanged before edge", pix_out, prev);
    @(negedge clk);
    check("R10 output after one edge", pix_out, 24'hFFEEDD);

    // parked far below the visible area
    place(300, 1663, 0, 0);
    for (int i = 0; i < 100; i++)
      chk_pix("R11 parked pointer invisible", int'($urandom_range(0, 1023)),
              int'($urandom_range(0, 1199)), 24'($urandom), 1'b1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R1-path run hung got=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule